// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous memory whose read and write data share one bidirectional bus. A new command (read or write) can be issued on every enabled clock, in any mix. Read data leaves through a registered output stage. Write data is taken from the bus at the same pipeline depth at which read data is presented. As a result, a read and a write never compete for the bus, and no idle cycle is needed when the direction changes.

Address, control and byte-write enables are registered on the rising clock edge. An active-low run input freezes the whole pipeline. Three chip-select pins with mixed polarity let several devices share one bus, which gives depth expansion. A load/advance input either starts a new access or continues a burst. A burst steps the two lowest address bits through a 2-bit counter in linear or interleaved order. The burst controller is a three-state machine:
- ST_IDLE means no burst is selected.
- ST_READ means a read burst is open.
- ST_WRITE means a write burst is open.

Its transitions are:
- LOAD_SEL enters ST_READ or ST_WRITE, following the read/write select.
- LOAD_DESEL returns to ST_IDLE.
- ADVANCE keeps the current state and steps the counter.

Top module: `zbt_sram`

## Requirements
- R1: Address, read/write select, chip selects, byte enables and burst controls are registered only on a rising clock edge at which run_n is low.
- R2: For a read registered at enabled edge E, the block drives the addressed word on dq from enabled edge E+1 until enabled edge E+2, where the host samples it.
- R3: For a write registered at enabled edge E, the word on dq is sampled at enabled edge E+2. The block never drives dq in that interval, so reads and writes may alternate on every enabled cycle.
- R4: bw_n bit i low writes byte i (dq bits 8i+7 down to 8i). bw_n bit i high leaves that byte of the stored word unchanged.
- R5: While run_n is high, no command is taken, no write is committed, and the value driven on dq is held.
- R6: A load cycle (burst_adv low) is selected only when sel_a_n is 0, sel_b is 1 and sel_c_n is 0. A deselected load performs no access, and burst advances after it perform no access either.
- R7: With burst_adv high, the block reuses the stored read/write select and base address and ignores the addr, rd_wr_n and chip-select pins. Each advance steps a 2-bit counter that wraps after four words.
- R8: With ilv_mode 0, the two low address bits of the k-th burst word are (start + k) mod 4.
- R9: With ilv_mode 1, the two low address bits of the k-th burst word are start XOR (k mod 4).
- R10: A read returns the value left by all earlier-issued writes, including a write still waiting for its data, merged byte by byte.
- R11: rst_n low resets the pipeline and the burst state at once, and the block stops driving dq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_n | input | 1 | Active-low clock enable; high stalls the pipeline |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_adv | input | 1 | 1 continues the burst, 0 loads a new address |
| rd_wr_n | input | 1 | 1 read, 0 write (load cycles only) |
| bw_n | input | N_BYTES | Per-byte write enables, active low |
| addr | input | ADDR_W | Word address (load cycles only) |
| ilv_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| dq | inout | N_BYTES*BYTE_W | Shared data bus |

## Verification
The following are checked by properties on every enabled cycle:
- the stall freeze of the output stage and the burst state;
- the exclusion between driving read data and expecting write data;
- the one-edge move of a read from the command stage to the output stage;
- the counter reset on a load and its single step on an advance;
- the return to idle on a deselected load.

Some behaviour can only be shown by the bench's scenarios against its own in-order memory model. This covers the data itself: byte-merged writes, read-after-write forwarding, the linear and interleaved burst address sequences including wrap, commands that are ignored while stalled or deselected, and the mid-access reset.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } burst_st_e;

    // Low two address bits of a burst word: interleaved XOR or linear add.
    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       ilv);
        burst_lo = ilv ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/zbt_burst_ctl.sv
module zbt_burst_ctl
    import zbt_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int N_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load_sel,
    input  logic              adv,
    input  logic              rd,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_BYTES-1:0] bw_n,
    output logic              cmd_valid,
    output logic              cmd_wr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [N_BYTES-1:0] cmd_be,
    output burst_st_e         state,
    output logic [1:0]        cnt
);

    localparam int HI_W = ADDR_W - 2;

    burst_st_e         st_q, st_d;
    logic [1:0]        cnt_q, cnt_d;
    logic [ADDR_W-1:0] base_q;
    logic [HI_W-1:0]   base_hi;

    assign base_hi = base_q[ADDR_W-1:2];

    // Next state: LOAD_SEL / LOAD_DESEL / ADVANCE
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!adv) begin
            cnt_d = 2'd0;
            if (!load_sel) st_d = ST_IDLE;
            else if (rd)   st_d = ST_READ;
            else           st_d = ST_WRITE;
        end else begin
            unique case (st_q)
                ST_IDLE:  cnt_d = cnt_q;
                ST_READ,
                ST_WRITE: cnt_d = cnt_q + 2'd1;
                default:  cnt_d = cnt_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= 2'd0;
            base_q <= '0;
        end else if (en) begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (!adv) base_q <= addr;
        end
    end

    // Command outputs for the cycle being registered
    always_comb begin
        cmd_be    = ~bw_n;
        cmd_addr  = addr;
        cmd_valid = 1'b0;
        cmd_wr    = 1'b0;
        if (!adv) begin
            cmd_valid = load_sel;
            cmd_wr    = !rd;
        end else begin
            cmd_addr = {base_hi, burst_lo(base_q[1:0], cnt_d, ilv)};
            unique case (st_q)
                ST_IDLE:  cmd_valid = 1'b0;
                ST_READ:  cmd_valid = 1'b1;
                ST_WRITE: begin
                    cmd_valid = 1'b1;
                    cmd_wr    = 1'b1;
                end
                default:  cmd_valid = 1'b0;
            endcase
        end
    end

    assign state = st_q;
    assign cnt   = cnt_q;

endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
    parameter int ADDR_W  = 6,
    parameter int N_BYTES = 4,
    parameter int BYTE_W  = 8
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [N_BYTES-1:0]        wbe,
    input  logic [N_BYTES*BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [N_BYTES*BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wbe[b]) lane_mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
        end

        assign rdata[b*BYTE_W +: BYTE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/zbt_fwd_merge.sv
module zbt_fwd_merge #(
    parameter int N_BYTES = 4,
    parameter int BYTE_W  = 8
) (
    input  logic                      hit,
    input  logic [N_BYTES-1:0]        be,
    input  logic [N_BYTES*BYTE_W-1:0] arr_word,
    input  logic [N_BYTES*BYTE_W-1:0] bus_word,
    output logic [N_BYTES*BYTE_W-1:0] word
);

    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        assign word[b*BYTE_W +: BYTE_W] = (hit && be[b])
            ? bus_word[b*BYTE_W +: BYTE_W]
            : arr_word[b*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int N_BYTES = 4,
    parameter int BYTE_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_n,
    input  logic                      sel_a_n,
    input  logic                      sel_b,
    input  logic                      sel_c_n,
    input  logic                      burst_adv,
    input  logic                      rd_wr_n,
    input  logic [N_BYTES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      ilv_mode,
    inout  wire  [N_BYTES*BYTE_W-1:0] dq
);

    localparam int DATA_W = N_BYTES * BYTE_W;

    logic en, sel_ok;
    assign en     = !run_n;
    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    logic              cmd_valid, cmd_wr;
    logic [ADDR_W-1:0] cmd_addr;
    logic [N_BYTES-1:0] cmd_be;
    burst_st_e         bst_state;
    logic [1:0]        bst_cnt;

    zbt_burst_ctl #(.ADDR_W(ADDR_W), .N_BYTES(N_BYTES)) u_ctl (
        .clk(clk), .rst_n(rst_n), .en(en), .load_sel(sel_ok),
        .adv(burst_adv), .rd(rd_wr_n), .ilv(ilv_mode), .addr(addr),
        .bw_n(bw_n), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
        .cmd_addr(cmd_addr), .cmd_be(cmd_be), .state(bst_state), .cnt(bst_cnt)
    );

    // Command stage (s1) and data stage (s2)
    logic               s1_valid, s1_wr, s2_valid, s2_wr;
    logic [ADDR_W-1:0]  s1_addr, s2_addr;
    logic [N_BYTES-1:0] s1_be, s2_be;
    logic [DATA_W-1:0]  dout_q, arr_word, rd_word;
    logic               oe_q, fwd_hit, mem_we;

    assign mem_we  = en && s2_valid && s2_wr;
    assign fwd_hit = s2_valid && s2_wr && (s2_addr == s1_addr);

    zbt_mem_array #(.ADDR_W(ADDR_W), .N_BYTES(N_BYTES), .BYTE_W(BYTE_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(s2_addr), .wbe(s2_be), .wdata(dq),
        .raddr(s1_addr), .rdata(arr_word)
    );

    zbt_fwd_merge #(.N_BYTES(N_BYTES), .BYTE_W(BYTE_W)) u_fwd (
        .hit(fwd_hit), .be(s2_be), .arr_word(arr_word), .bus_word(dq),
        .word(rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_wr    <= 1'b0;
            s1_addr  <= '0;
            s1_be    <= '0;
            s2_valid <= 1'b0;
            s2_wr    <= 1'b0;
            s2_addr  <= '0;
            s2_be    <= '0;
            oe_q     <= 1'b0;
            dout_q   <= '0;
        end else if (en) begin
            s1_valid <= cmd_valid;
            s1_wr    <= cmd_wr;
            s1_addr  <= cmd_addr;
            s1_be    <= cmd_be;
            s2_valid <= s1_valid;
            s2_wr    <= s1_wr;
            s2_addr  <= s1_addr;
            s2_be    <= s1_be;
            oe_q     <= s1_valid && !s1_wr;
            if (s1_valid && !s1_wr) dout_q <= rd_word;
        end
    end

    assign dq = oe_q ? dout_q : {DATA_W{1'bz}};

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk
    import zbt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_n,
    input logic              burst_adv,
    input logic              sel_ok,
    input logic              s1_valid,
    input logic              s1_wr,
    input logic              s2_valid,
    input logic              s2_wr,
    input logic              oe_q,
    input logic [DATA_W-1:0] dout_q,
    input burst_st_e         bst_state,
    input logic [1:0]        bst_cnt
);

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(oe_q && s2_valid && s2_wr)); // R3

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_n && s1_valid && !s1_wr) |=> oe_q); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        run_n |=> ($stable(oe_q) && $stable(dout_q) && $stable(bst_state))); // R5

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_n && !burst_adv && !sel_ok) |=> (bst_state == ST_IDLE && !s1_valid)); // R6

    AST_LOAD_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_n && !burst_adv) |=> (bst_cnt == 2'd0)); // R7

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_n && burst_adv && bst_state != ST_IDLE) |=> (bst_cnt == $past(bst_cnt) + 2'd1)); // R7

endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(N_BYTES*BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_n(run_n), .burst_adv(burst_adv),
    .sel_ok(sel_ok), .s1_valid(s1_valid), .s1_wr(s1_wr),
    .s2_valid(s2_valid), .s2_wr(s2_wr), .oe_q(oe_q), .dout_q(dout_q),
    .bst_state(bst_state), .bst_cnt(bst_cnt)
);

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_n = 1'b0;
    logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic        burst_adv = 1'b0, rd_wr_n = 1'b1, ilv_mode = 1'b0;
    logic [3:0]  bw_n = 4'hF;
    logic [5:0]  addr = '0;
    wire  [31:0] dq;
    logic        tb_oe = 1'b0;
    logic [31:0] tb_dq = '0;

    assign dq = tb_oe ? tb_dq : 32'bz;

    always #(CLK_PERIOD/2) clk = ~clk;

    zbt_sram dut (
        .clk(clk), .rst_n(rst_n), .run_n(run_n), .sel_a_n(sel_a_n),
        .sel_b(sel_b), .sel_c_n(sel_c_n), .burst_adv(burst_adv),
        .rd_wr_n(rd_wr_n), .bw_n(bw_n), .addr(addr), .ilv_mode(ilv_mode),
        .dq(dq)
    );

    int checks = 0, failures = 0;
    string cur_tag = "R1";
    int unsigned seed = 32'h1234_5678;

    // Behavioural model: in-order memory plus two-entry issue history
    logic [31:0] mm [64];
    logic        h_valid [2];
    logic        h_wr    [2];
    logic [31:0] h_data  [2];
    logic        b_active = 1'b0, b_wr = 1'b0;
    int          b_base = 0, b_k = 0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic clear_hist();
        for (int i = 0; i < 2; i++) begin
            h_valid[i] = 1'b0; h_wr[i] = 1'b0; h_data[i] = '0;
        end
        b_active = 1'b0; b_k = 0;
    endtask

    task automatic model_issue(input logic av, input logic [2:0] sb, input logic rd,
                               input logic [5:0] a, input logic [3:0] bwn,
                               input logic il, input logic [31:0] wd);
        int eff, lo;
        logic v;
        eff = a;
        if (!av) begin
            if (sb == 3'b010) begin
                b_active = 1'b1; b_wr = !rd; b_base = a; b_k = 0;
            end else b_active = 1'b0;
        end else if (b_active) begin
            b_k = (b_k + 1) % 4;
            lo  = il ? ((b_base % 4) ^ b_k) : (((b_base % 4) + b_k) % 4);
            eff = b_base - (b_base % 4) + lo;
        end
        v = b_active;
        h_valid[1] = h_valid[0]; h_wr[1] = h_wr[0]; h_data[1] = h_data[0];
        h_valid[0] = v;
        h_wr[0]    = b_wr;
        if (v && b_wr) begin
            for (int i = 0; i < 4; i++)
                if (!bwn[i]) mm[eff][i*8 +: 8] = wd[i*8 +: 8];
            h_data[0] = wd;
        end else if (v) h_data[0] = mm[eff];
        else h_data[0] = '0;
    endtask

    task automatic tick(input logic rn, input logic av, input logic [2:0] sb,
                        input logic rd, input logic [5:0] a, input logic [3:0] bwn,
                        input logic il);
        logic [31:0] wd;
        @(negedge clk);
        if (h_valid[1] && h_wr[1]) begin
            tb_oe = 1'b1; tb_dq = h_data[1];
        end else tb_oe = 1'b0;
        #1;
        if (h_valid[1]) check(dq, h_data[1], h_wr[1] ? "R3" : cur_tag);
        run_n = rn; burst_adv = av;
        {sel_a_n, sel_b, sel_c_n} = sb;
        rd_wr_n = rd; addr = a; bw_n = bwn; ilv_mode = il;
        seed = seed * 32'd1103515245 + 32'd12345;
        wd = seed;
        @(posedge clk);
        if (!rn) model_issue(av, sb, rd, a, bwn, il, wd);
        #1 tb_oe = 1'b0;
    endtask

    task automatic t_wr(input logic [5:0] a, input logic [3:0] bwn);
        tick(1'b0, 1'b0, 3'b010, 1'b0, a, bwn, 1'b0);
    endtask
    task automatic t_rd(input logic [5:0] a);
        tick(1'b0, 1'b0, 3'b010, 1'b1, a, 4'hF, 1'b0);
    endtask
    task automatic t_nop();
        tick(1'b0, 1'b0, 3'b110, 1'b1, 6'd0, 4'hF, 1'b0);
    endtask
    task automatic t_adv(input logic il, input logic [3:0] bwn);
        tick(1'b0, 1'b1, 3'b101, 1'b0, 6'd63, bwn, il);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mm[i] = '0;
        clear_hist();
        // R11: block does not drive dq in reset
        tb_oe = 1'b1; tb_dq = 32'h5A5A_A5A5;
        repeat (3) @(negedge clk);
        check(dq, 32'h5A5A_A5A5, "R11");
        tb_oe = 1'b0;
        rst_n = 1'b1;

        // R1: fill every word with full writes
        cur_tag = "R1";
        for (int i = 0; i < 64; i++) t_wr(6'(i), 4'h0);
        for (int i = 0; i < 64; i += 7) t_rd(6'(i));
        t_nop(); t_nop();

        // R2: consecutive reads
        cur_tag = "R2";
        for (int i = 0; i < 6; i++) t_rd(6'(i * 5));
        t_nop(); t_nop();

        // R3: alternating reads and writes with no idle cycle
        cur_tag = "R3";
        for (int i = 0; i < 8; i++) begin
            t_rd(6'(i + 10));
            t_wr(6'(i + 40), 4'h0);
        end
        t_nop(); t_nop();

        // R4: byte masked writes, read back after drain
        cur_tag = "R4";
        t_wr(6'd5, 4'b1010); t_nop(); t_nop(); t_rd(6'd5);
        t_wr(6'd6, 4'b1111); t_nop(); t_nop(); t_rd(6'd6);
        t_wr(6'd7, 4'b0111); t_nop(); t_nop(); t_rd(6'd7);
        t_nop(); t_nop();

        // R10: read right behind pending writes to the same word
        cur_tag = "R10";
        t_wr(6'd9, 4'b0110); t_rd(6'd9);
        t_wr(6'd9, 4'b0000); t_rd(6'd9); t_rd(6'd9);
        t_wr(6'd8, 4'b1001); t_wr(6'd8, 4'b1110); t_rd(6'd8);
        t_nop(); t_nop();

        // R6: each chip select inactive in turn, then advances
        cur_tag = "R6";
        tick(1'b0, 1'b0, 3'b110, 1'b0, 6'd20, 4'h0, 1'b0);
        t_adv(1'b0, 4'h0);
        tick(1'b0, 1'b0, 3'b000, 1'b0, 6'd21, 4'h0, 1'b0);
        t_adv(1'b0, 4'h0);
        tick(1'b0, 1'b0, 3'b011, 1'b0, 6'd22, 4'h0, 1'b0);
        t_nop(); t_nop();
        t_rd(6'd20); t_rd(6'd21); t_rd(6'd22); t_rd(6'd23);
        t_nop(); t_nop();

        // R7, R8: linear read burst from low bits 2, five advances (wrap)
        cur_tag = "R8";
        t_rd(6'd14);
        for (int k = 0; k < 5; k++) t_adv(1'b0, 4'hF);
        t_nop(); t_nop();
        cur_tag = "R7";
        tick(1'b0, 1'b0, 3'b010, 1'b0, 6'd25, 4'h0, 1'b0);
        for (int k = 0; k < 3; k++) t_adv(1'b0, 4'h0);
        t_nop(); t_nop();
        for (int i = 24; i < 28; i++) t_rd(6'(i));
        t_nop(); t_nop();

        // R9: interleaved bursts
        cur_tag = "R9";
        tick(1'b0, 1'b0, 3'b010, 1'b1, 6'd33, 4'hF, 1'b1);
        for (int k = 0; k < 4; k++) t_adv(1'b1, 4'hF);
        tick(1'b0, 1'b0, 3'b010, 1'b0, 6'd43, 4'h0, 1'b1);
        for (int k = 0; k < 3; k++) t_adv(1'b1, 4'b0101);
        t_nop(); t_nop();
        for (int i = 40; i < 44; i++) t_rd(6'(i));
        t_nop(); t_nop();

        // R5: stall holds read data and ignores a write
        cur_tag = "R5";
        t_rd(6'd30); t_rd(6'd31);
        tick(1'b1, 1'b0, 3'b010, 1'b0, 6'd30, 4'h0, 1'b0);
        tick(1'b1, 1'b0, 3'b010, 1'b0, 6'd31, 4'h0, 1'b0);
        tick(1'b1, 1'b0, 3'b010, 1'b0, 6'd30, 4'h0, 1'b0);
        t_nop(); t_nop();
        t_rd(6'd30); t_rd(6'd31);
        t_nop(); t_nop();

        // R11: reset during an access stops driving
        cur_tag = "R11";
        t_rd(6'd2); t_rd(6'd3);
        @(negedge clk);
        rst_n = 1'b0;
        tb_oe = 1'b1; tb_dq = 32'hC3C3_3C3C;
        #1 check(dq, 32'hC3C3_3C3C, "R11");
        @(negedge clk);
        tb_oe = 1'b0;
        rst_n = 1'b1;
        clear_hist();
        t_rd(6'd2); t_nop(); t_nop();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule